// File: doc/BRIEF.md
# Banked Display RAM Write Controller

This block holds the segment pattern for a multiplexed LCD: a bit array of 8 rows by 60 columns. Each row drives one backplane and each column drives one segment output. A host pushes data bytes one at a time with a write strobe. An auto-advancing data pointer places each byte into the array. How the eight bits of a byte are spread over rows and columns depends on the multiplex drive mode.

In the lower multiplex modes the rows split into banks. The bank that receives writes and the bank that is displayed are chosen independently, so the next frame can be built out of sight and then switched in with one bank change. The display scan logic reads single cells through a registered column/backplane port.

Top module: `lcd_bank_ram`

## Requirements
- R1: Reset clears every cell to 0, sets the data pointer `wr_ptr` to 0, and sets both bank selects to 0.
- R2: In mode 3 (1:8), a byte fills one column. Bit 7 goes to row 0 and so on down to bit 0 at row 7. The input bank has no effect, so the base row is 0.
- R3: Each accepted byte advances `wr_ptr` by the number of columns it covers: 8 in mode 0 (static), 4 in mode 1 (1:2), 2 in mode 2 (1:4) and 1 in mode 3. The advance is modulo 60, so after column 59 the next column is 0.
- R4: In mode 2 (1:4), bits 7..4 go to column p, rows base..base+3, in that order. Bits 3..0 go to column p+1 (mod 60) in the same way.
- R5: In mode 1, each column takes 2 bits in rows base and base+1, MSB first. In mode 0, each column takes 1 bit in row base. In both modes the columns run upward from p and wrap past column 59.
- R6: Rows per bank are 1, 2, 4 and 8 for modes 0 to 3. The base row is (bank mod (8 / rows per bank)) × rows per bank.
- R7: The output bank is independent of the input bank. A read returns the cell at column `rd_col`, row output base + (`rd_bp` mod rows per bank). Any `rd_col` above 59 returns 0.
- R8: `rd_bit` appears one clock after the read address. A write to the same cell in the same cycle returns the old value.
- R9: `ptr_load` sets `wr_ptr` to `ptr_val`, or to 0 if `ptr_val` is above 59. When `ptr_load` and `wr_en` are high together, the load wins and the byte is discarded.
- R10: `ibank_we` and `obank_we` each load their own bank select from `ibank_val` and `obank_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Multiplex mode: 0 static, 1 1:2, 2 1:4, 3 1:8 |
| wr_en | input | 1 | Data byte strobe |
| wr_data | input | 8 | Data byte |
| ptr_load | input | 1 | Load the data pointer |
| ptr_val | input | 6 | Pointer load value |
| ibank_we | input | 1 | Load input bank select |
| ibank_val | input | 3 | Input bank value |
| obank_we | input | 1 | Load output bank select |
| obank_val | input | 3 | Output bank value |
| rd_col | input | 6 | Read column |
| rd_bp | input | 3 | Read backplane index |
| rd_bit | output | 1 | Registered read data |
| wr_ptr | output | 6 | Current data pointer |

## Verification
A byte, pointer load or bank load changes state at the first rising edge after it is driven. The bench therefore checks `wr_ptr` at the falling edge after that edge. Cell contents are visible only through the read port, which adds one register. Each read presents its address at a falling edge and compares `rd_bit` at the next falling edge. The collision test samples the old value there, then repeats the read one cycle later to see the new value.

// File: rtl/lcd_bank_pkg.sv
package lcd_bank_pkg;
  localparam int COLS   = 60;
  localparam int ROWS   = 8;
  localparam int BYTE_W = 8;
  localparam int CW     = $clog2(COLS);
  localparam int RW     = $clog2(ROWS);

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_2      = 2'd1,
    MUX_4      = 2'd2,
    MUX_8      = 2'd3
  } mux_mode_e;

  // rows owned by one bank: 1, 2, 4, 8
  function automatic logic [RW:0] rows_per_bank(mux_mode_e m);
    return (RW+1)'(1) << m;
  endfunction

  // columns covered by one byte: 8, 4, 2, 1
  function automatic logic [CW-1:0] cols_per_byte(mux_mode_e m);
    return CW'(BYTE_W >> m);
  endfunction

  // column arithmetic modulo COLS (base < COLS, off <= BYTE_W)
  function automatic logic [CW-1:0] col_wrap(logic [CW-1:0] base, logic [CW-1:0] off);
    logic [CW:0] s;
    s = {1'b0, base} + {1'b0, off};
    if (s >= (CW+1)'(COLS)) s = s - (CW+1)'(COLS);
    return s[CW-1:0];
  endfunction

  // base row of a bank; truncation performs the bank modulo
  function automatic logic [RW-1:0] bank_base(mux_mode_e m, logic [RW-1:0] bank);
    logic [RW-1:0] t;
    t = bank << m;
    return t;
  endfunction
endpackage

// File: rtl/lcd_ptr.sv
module lcd_ptr
  import lcd_bank_pkg::*;
#(
  parameter int NCOL = COLS,
  localparam int PW  = $clog2(NCOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          adv,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] ptr
);
  logic          load_oob;
  logic [PW-1:0] load_eff;
  logic [PW:0]   sum;
  logic [PW-1:0] next_adv;

  assign load_oob = (load_val >= PW'(NCOL));
  assign load_eff = load_oob ? '0 : load_val;
  assign sum      = {1'b0, ptr} + {1'b0, step};
  assign next_adv = (sum >= (PW+1)'(NCOL)) ? PW'(sum - (PW+1)'(NCOL)) : sum[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_eff;
    else if (adv)  ptr <= next_adv;
  end

  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(NCOL));
  a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_oob) |=> (ptr == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(ptr));
endmodule

// File: rtl/lcd_bank_regs.sv
module lcd_bank_regs
  import lcd_bank_pkg::*;
#(
  parameter int NROW = ROWS,
  localparam int BW  = $clog2(NROW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mux_mode_e     mode,
  input  logic          ibank_we,
  input  logic [BW-1:0] ibank_val,
  input  logic          obank_we,
  input  logic [BW-1:0] obank_val,
  output logic [BW-1:0] in_base,
  output logic [BW-1:0] out_base
);
  logic [BW-1:0] in_bank_q, out_bank_q;
  logic [BW:0]   rpb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_bank_q  <= '0;
      out_bank_q <= '0;
    end else begin
      if (ibank_we) in_bank_q  <= ibank_val;
      if (obank_we) out_bank_q <= obank_val;
    end
  end

  assign rpb      = rows_per_bank(mode);
  assign in_base  = bank_base(mode, in_bank_q);
  assign out_base = bank_base(mode, out_bank_q);

  // R6: a base row always sits on a bank boundary of the current mode
  a_r6_in_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, in_base} & (rpb - 1'b1)) == '0);
  a_r6_out_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, out_base} & (rpb - 1'b1)) == '0);
endmodule

// File: rtl/lcd_cell_array.sv
module lcd_cell_array
  import lcd_bank_pkg::*;
#(
  parameter int NCOL = COLS,
  parameter int NROW = ROWS,
  parameter int DW   = BYTE_W,
  localparam int PW  = $clog2(NCOL),
  localparam int BW  = $clog2(NROW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mux_mode_e     mode,
  input  logic          byte_write,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] wr_ptr,
  input  logic [BW-1:0] in_base,
  input  logic [PW-1:0] rd_col,
  input  logic [BW-1:0] rd_row,
  output logic          rd_bit
);
  logic [NCOL-1:0] mem [NROW];
  logic [PW-1:0]   tgt_col [DW];
  logic [BW-1:0]   tgt_row [DW];
  logic [BW:0]     rpb_mask;
  logic            rd_hit;

  assign rpb_mask = rows_per_bank(mode) - 1'b1;
  assign rd_hit   = (rd_col < PW'(NCOL));

  // bit k of the byte (counted from the MSB) lands at column offset k/rpb, row offset k%rpb
  for (genvar k = 0; k < DW; k++) begin : g_tgt
    assign tgt_col[k] = col_wrap(wr_ptr, PW'(k >> mode));
    assign tgt_row[k] = in_base + BW'((BW+1)'(k) & rpb_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROW; r++) mem[r] <= '0;
      rd_bit <= 1'b0;
    end else begin
      if (byte_write)
        for (int k = 0; k < DW; k++) mem[tgt_row[k]][tgt_col[k]] <= wr_data[DW-1-k];
      rd_bit <= rd_hit ? mem[rd_row][rd_col] : 1'b0;
    end
  end

  a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !rd_bit);
  a_r2_column_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MUX_8) |-> (tgt_col[DW-1] == wr_ptr && tgt_row[DW-1] == BW'(DW-1)));
endmodule

// File: rtl/lcd_bank_ram.sv
module lcd_bank_ram
  import lcd_bank_pkg::*;
#(
  parameter int NCOL = COLS,
  parameter int NROW = ROWS,
  parameter int DW   = BYTE_W,
  localparam int PW  = $clog2(NCOL),
  localparam int BW  = $clog2(NROW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_val,
  input  logic          ibank_we,
  input  logic [BW-1:0] ibank_val,
  input  logic          obank_we,
  input  logic [BW-1:0] obank_val,
  input  logic [PW-1:0] rd_col,
  input  logic [BW-1:0] rd_bp,
  output logic          rd_bit,
  output logic [PW-1:0] wr_ptr
);
  mux_mode_e     mode_e;
  logic          byte_accept;
  logic [PW-1:0] step;
  logic [BW-1:0] in_base, out_base, rd_row;
  logic [BW:0]   rpb_mask;

  assign mode_e      = mux_mode_e'(mode);
  assign byte_accept = wr_en && !ptr_load;
  assign step        = PW'(cols_per_byte(mode_e));
  assign rpb_mask    = rows_per_bank(mode_e) - 1'b1;
  assign rd_row      = out_base + BW'({1'b0, rd_bp} & rpb_mask);

  lcd_ptr #(.NCOL(NCOL)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_val),
    .adv(byte_accept), .step(step), .ptr(wr_ptr)
  );

  lcd_bank_regs #(.NROW(NROW)) u_banks (
    .clk(clk), .rst_n(rst_n), .mode(mode_e),
    .ibank_we(ibank_we), .ibank_val(ibank_val),
    .obank_we(obank_we), .obank_val(obank_val),
    .in_base(in_base), .out_base(out_base)
  );

  lcd_cell_array #(.NCOL(NCOL), .NROW(NROW), .DW(DW)) u_cells (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .byte_write(byte_accept),
    .wr_data(wr_data), .wr_ptr(wr_ptr), .in_base(in_base),
    .rd_col(rd_col), .rd_row(rd_row), .rd_bit(rd_bit)
  );

  // R9: a load and a byte in one cycle leave the pointer at the load target, not one step past it
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && wr_en && ptr_val == '0) |=> (wr_ptr == '0));
endmodule

// File: tb/lcd_bank_ram_tb.sv
module lcd_bank_ram_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ptr_load = 1'b0;
  logic [5:0] ptr_val = 6'd0;
  logic       ibank_we = 1'b0;
  logic [2:0] ibank_val = 3'd0;
  logic       obank_we = 1'b0;
  logic [2:0] obank_val = 3'd0;
  logic [5:0] rd_col = 6'd0;
  logic [2:0] rd_bp = 3'd0;
  logic       rd_bit;
  logic [5:0] wr_ptr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit model [8][60];
  int bptr = 0;

  always #4 clk = ~clk;

  lcd_bank_ram u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .ibank_we(ibank_we), .ibank_val(ibank_val),
    .obank_we(obank_we), .obank_val(obank_val), .rd_col(rd_col), .rd_bp(rd_bp),
    .rd_bit(rd_bit), .wr_ptr(wr_ptr)
  );

  // vector: {mode[2], ibank[3], load[1], load value[6], data[8]}
  localparam logic [19:0] VEC [12] = '{
    {2'd3, 3'd0, 1'b0, 6'd0,  8'hA5},
    {2'd3, 3'd5, 1'b0, 6'd0,  8'h3C},
    {2'd2, 3'd0, 1'b0, 6'd0,  8'h9E},
    {2'd2, 3'd1, 1'b0, 6'd0,  8'h71},
    {2'd1, 3'd2, 1'b0, 6'd0,  8'hC6},
    {2'd1, 3'd7, 1'b0, 6'd0,  8'hB3},
    {2'd0, 3'd3, 1'b0, 6'd0,  8'h5A},
    {2'd3, 3'd0, 1'b1, 6'd59, 8'hE7},
    {2'd0, 3'd6, 1'b1, 6'd56, 8'h96},
    {2'd2, 3'd0, 1'b1, 6'd59, 8'h4D},
    {2'd1, 3'd1, 1'b1, 6'd58, 8'h2B},
    {2'd3, 3'd0, 1'b1, 6'd61, 8'h11}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 8; r++) for (int c = 0; c < 60; c++) model[r][c] = 1'b0;
    bptr = 0;
  endtask

  // reference placement: column j of the byte, row k of the bank
  task automatic model_write(int m, int bank, logic [7:0] d);
    int rpb, cpb, base;
    rpb  = 1 << m;
    cpb  = 8 / rpb;
    base = (bank % cpb) * rpb;
    for (int j = 0; j < cpb; j++)
      for (int k = 0; k < rpb; k++)
        model[base + k][(bptr + j) % 60] = d[7 - (j * rpb + k)];
    bptr = (bptr + cpb) % 60;
  endtask

  task automatic pulse_byte(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ibank(logic [2:0] b);
    ibank_we = 1'b1; ibank_val = b;
    @(negedge clk);
    ibank_we = 1'b0;
  endtask

  task automatic set_obank(logic [2:0] b);
    obank_we = 1'b1; obank_val = b;
    @(negedge clk);
    obank_we = 1'b0;
  endtask

  task automatic load_ptr(logic [5:0] v);
    ptr_load = 1'b1; ptr_val = v;
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  task automatic read_cell(int c, int bp, output int v);
    rd_col = 6'(c); rd_bp = 3'(bp);
    @(negedge clk);
    v = int'(rd_bit);
  endtask

  // full readback through mode 3, where backplane index equals the row
  task automatic readback(string req);
    int v;
    mode = 2'd3;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 60; c++) begin
        read_cell(c, r, v);
        check(req, v, int'(model[r][c]));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, m;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ptr", int'(wr_ptr), 0);
    read_cell(0, 0, v);   check("R1 cell", v, 0);
    read_cell(59, 7, v);  check("R1 cell", v, 0);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < 12; i++) begin
      m = int'(VEC[i][19:18]);
      mode = VEC[i][19:18];
      set_ibank(VEC[i][17:15]);
      if (VEC[i][14]) begin
        load_ptr(VEC[i][13:8]);
        bptr = (VEC[i][13:8] > 6'd59) ? 0 : int'(VEC[i][13:8]);
        check("R9 load", int'(wr_ptr), bptr);
      end
      pulse_byte(VEC[i][7:0]);
      model_write(m, int'(VEC[i][17:15]), VEC[i][7:0]);
      check("R3 advance", int'(wr_ptr), bptr);
    end
    readback("R2 R4 R5 R6 R10 placement");

    // R7: output bank independent of input bank, backplane wraps within the bank
    mode = 2'd2;
    set_ibank(3'd0);
    set_obank(3'd1);
    read_cell(4, 0, v); check("R7 obank row4", v, int'(model[4][4]));
    read_cell(5, 3, v); check("R7 obank row7", v, int'(model[7][5]));
    read_cell(4, 6, v); check("R7 bp mod", v, int'(model[6][4]));
    mode = 2'd1;
    set_obank(3'd6);
    read_cell(10, 1, v); check("R7 mode1 bank6", v, int'(model[5][10]));
    mode = 2'd0;
    set_obank(3'd3);
    read_cell(14, 5, v); check("R7 static bank3", v, int'(model[3][14]));
    read_cell(60, 0, v); check("R7 col 60", v, 0);
    read_cell(63, 0, v); check("R7 col 63", v, 0);

    // R8: collision returns old data, then new
    mode = 2'd3;
    set_obank(3'd0);
    load_ptr(6'd30);
    bptr = 30;
    rd_col = 6'd30; rd_bp = 3'd0;
    wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 old data", int'(rd_bit), int'(model[0][30]));
    model_write(3, 0, 8'hFF);
    @(negedge clk);
    check("R8 new data", int'(rd_bit), 1);

    // R9: load wins over a byte in the same cycle, byte discarded
    ptr_load = 1'b1; ptr_val = 6'd40; wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    ptr_load = 1'b0; wr_en = 1'b0;
    bptr = 40;
    check("R9 load priority", int'(wr_ptr), 40);
    for (int r = 0; r < 8; r++) begin
      read_cell(40, r, v); check("R9 byte dropped", v, 0);
    end
    load_ptr(6'd60);
    check("R9 clamp 60", int'(wr_ptr), 0);

    // R1: mid-run reset clears RAM, pointer and bank selects
    mode = 2'd0;
    set_ibank(3'd5);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check("R1 ptr after reset", int'(wr_ptr), 0);
    pulse_byte(8'h81);
    model_write(0, 0, 8'h81);
    check("R1 R3 static step", int'(wr_ptr), 8);
    readback("R1 bank zero after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule